// File: doc/BRIEF.md
# Multi-Mode Floating-Point Minimum/Maximum Unit

This block picks the smaller or larger of two double-precision operands under one of sixteen rule sets chosen by a 4-bit mode code. The rule sets cover the 2008-style number-preferring choice, the 2019 NaN-propagating choice, the 2019 number-preferring choice and a plain compare-and-select. Each of these has a magnitude-first variant. The magnitude variant compares absolute values and falls back to the base rule when the magnitudes tie or an operand is a NaN.

The unit is a single register stage. Operands, mode and a record request are sampled on a clock edge with `in_valid`. On the next cycle the chosen value, an invalid-operation flag for signalling NaN inputs, and an optional 4-bit condition summary appear on the outputs. The condition summary compares A with B. A datapath uses the unit as the execute stage of a min/max operation, or chains it to reduce a vector to one extreme value.

Top module: `fminmax_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `res`, `flag_invalid`, `cond_valid` and `cond` are all zero.
- R2: `out_valid` in a cycle equals `in_valid` sampled at the previous rising edge. `res`, `flag_invalid`, `cond` and `cond_valid` reflect the inputs sampled at that same edge.
- R3: Rule 00, the 2008 number-preferring rule, works as follows.
  - If either operand is a signalling NaN, it returns that operand quieted, preferring A.
  - If both operands are quiet NaNs, it returns A quieted.
  - If exactly one operand is a quiet NaN, it returns the other operand unchanged.
  - Otherwise it returns the ordered choice, in which -0 orders below +0.
- R4: Rule 01, the 2019 NaN-propagating rule, returns the first NaN operand quieted, checking A before B. Otherwise it returns the ordered choice, in which -0 orders below +0.
- R5: Rule 10, the 2019 number-preferring rule, works as follows.
  - If both operands are NaN, it returns A quieted.
  - If exactly one operand is a NaN, quiet or signalling, it returns the other operand unchanged.
  - Otherwise it returns the ordered choice, in which -0 orders below +0.
- R6: Rule 11, the plain compare-and-select, treats the two zeros as equal.
  - Min returns A when A < B numerically, and otherwise B.
  - Max returns A when A > B numerically, and otherwise B.
  - A NaN in either operand therefore yields B unchanged.
- R7: Mode bit 2 selects the magnitude variant, which applies only when neither operand is a NaN. It compares bits 62:0 of the two operands as unsigned integers. A strict win returns the winning operand unchanged; min favours the smaller magnitude and max the larger. A tie or a NaN operand applies the base rule given by the other mode bits.
- R8: The mode code is {max, magnitude, rule[1:0]}. Bit 3 set selects maximum and bit 3 clear selects minimum.
- R9: A NaN returned by rules 00, 01 or 10 keeps all of its bits and has mantissa bit 51 forced to 1.
- R10: `flag_invalid` is 1 exactly when either sampled operand is a signalling NaN, in every mode. A signalling NaN has exponent bits 62:52 all ones, a non-zero mantissa and bit 51 clear.
- R11: The condition summary depends on the record request.
  - With `rec_en` set, `cond_valid` is 1 and `cond` holds one set bit: bit 3 for A<B, bit 2 for A>B, bit 1 for A=B (+0 equals -0) and bit 0 for unordered (either operand is NaN).
  - With `rec_en` clear, `cond` and `cond_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| op_a | input | 64 | Operand A, IEEE 754 double |
| op_b | input | 64 | Operand B, IEEE 754 double |
| mode | input | 4 | {max, magnitude, rule[1:0]} |
| rec_en | input | 1 | Request the condition summary |
| out_valid | output | 1 | Result registered from a valid input |
| res | output | 64 | Selected value |
| flag_invalid | output | 1 | A signalling NaN was an input |
| cond_valid | output | 1 | `cond` carries a summary |
| cond | output | 4 | {lt, gt, eq, unordered} of A against B |

## Verification
A directed set sweeps all sixteen modes over the following pairs:
- opposite zeros, which separate the signed-zero ordering of the IEEE rules from the plain select;
- one or two quiet NaNs, which separate propagating from number-preferring rules;
- signalling NaNs, which separate the 2008 rule from the 2019 number-preferring rule and exercise the flag;
- equal magnitudes of opposite sign, which force the magnitude fallback;
- infinities and subnormals.

Seeded random pairs then draw from the same classes plus ordinary normals. Some draws make B the negation or a copy of A, so ties and magnitude fallbacks recur. Every result is compared against a bench model built on real-number comparison.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

    typedef enum logic [1:0] {
        RULE_NUM08 = 2'b00,
        RULE_PROP19 = 2'b01,
        RULE_NUM19 = 2'b10,
        RULE_PLAIN = 2'b11
    } rule_e;

    localparam int COND_W = 4;
    localparam int COND_LT = 3;
    localparam int COND_GT = 2;
    localparam int COND_EQ = 1;
    localparam int COND_UN = 0;

endpackage

// File: rtl/fmm_classify.sv
module fmm_classify #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    localparam int DATA_W = 1 + EXP_W + MAN_W
) (
    input  logic [DATA_W-1:0] x,
    output logic              is_nan,
    output logic              is_snan,
    output logic              is_zero
);
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;
    logic             exp_ones;
    logic             man_nz;

    always_comb begin
        ex       = x[DATA_W-2 -: EXP_W];
        mn       = x[MAN_W-1:0];
        exp_ones = &ex;
        man_nz   = |mn;
        is_nan   = exp_ones && man_nz;
        // quiet bit is the top mantissa bit; clear means signalling
        is_snan  = is_nan && !mn[MAN_W-1];
        is_zero  = (ex == '0) && !man_nz;
    end
endmodule

// File: rtl/fmm_order.sv
module fmm_order #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    localparam int DATA_W = 1 + EXP_W + MAN_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              a_nan,
    input  logic              b_nan,
    input  logic              a_zero,
    input  logic              b_zero,
    output logic              key_lt,
    output logic              key_gt,
    output logic              num_lt,
    output logic              num_gt,
    output logic              num_eq,
    output logic              unord,
    output logic              mag_lt,
    output logic              mag_gt
);
    logic [DATA_W-1:0] key_a;
    logic [DATA_W-1:0] key_b;
    logic [DATA_W-2:0] mag_a;
    logic [DATA_W-2:0] mag_b;
    logic              both_zero;

    // Sign-magnitude mapped onto an unsigned total order: negatives are
    // inverted, positives get the top bit set, so -0 lands just below +0.
    always_comb begin
        key_a     = a[DATA_W-1] ? ~a : {1'b1, a[DATA_W-2:0]};
        key_b     = b[DATA_W-1] ? ~b : {1'b1, b[DATA_W-2:0]};
        mag_a     = a[DATA_W-2:0];
        mag_b     = b[DATA_W-2:0];
        both_zero = a_zero && b_zero;
        unord     = a_nan || b_nan;

        key_lt    = key_a < key_b;
        key_gt    = key_a > key_b;

        num_lt    = !unord && key_lt && !both_zero;
        num_gt    = !unord && key_gt && !both_zero;
        num_eq    = !unord && ((a == b) || both_zero);

        mag_lt    = !unord && (mag_a < mag_b);
        mag_gt    = !unord && (mag_a > mag_b);
    end
endmodule

// File: rtl/fmm_select.sv
module fmm_select
    import fmm_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    localparam int DATA_W = 1 + EXP_W + MAN_W
) (
    input  logic [3:0]        mode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              a_nan,
    input  logic              b_nan,
    input  logic              a_snan,
    input  logic              b_snan,
    input  logic              key_lt,
    input  logic              key_gt,
    input  logic              num_lt,
    input  logic              num_gt,
    input  logic              mag_lt,
    input  logic              mag_gt,
    output logic [DATA_W-1:0] res
);
    localparam logic [DATA_W-1:0] QBIT = DATA_W'(1) << (MAN_W - 1);

    logic              pick_max;
    logic              use_mag;
    rule_e             rule;
    logic [DATA_W-1:0] qa;
    logic [DATA_W-1:0] qb;
    logic [DATA_W-1:0] ordered;
    logic [DATA_W-1:0] plain;
    logic [DATA_W-1:0] base;

    always_comb begin
        pick_max = mode[3];
        use_mag  = mode[2];
        rule     = rule_e'(mode[1:0]);
        qa       = a | QBIT;
        qb       = b | QBIT;

        // signed-zero aware choice: ties in key only occur for equal bits
        if (pick_max) ordered = key_lt ? b : a;
        else          ordered = key_gt ? b : a;

        if (pick_max) plain = num_gt ? a : b;
        else          plain = num_lt ? a : b;

        unique case (rule)
            RULE_NUM08: begin
                if (a_snan)              base = qa;
                else if (b_snan)         base = qb;
                else if (a_nan && b_nan) base = qa;
                else if (a_nan)          base = b;
                else if (b_nan)          base = a;
                else                     base = ordered;
            end
            RULE_PROP19: begin
                if (a_nan)      base = qa;
                else if (b_nan) base = qb;
                else            base = ordered;
            end
            RULE_NUM19: begin
                if (a_nan && b_nan) base = qa;
                else if (a_nan)     base = b;
                else if (b_nan)     base = a;
                else                base = ordered;
            end
            default: base = plain;
        endcase

        res = base;
        if (use_mag) begin
            if (mag_lt)      res = pick_max ? b : a;
            else if (mag_gt) res = pick_max ? a : b;
        end
    end
endmodule

// File: rtl/fminmax_unit.sv
module fminmax_unit
    import fmm_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    localparam int DATA_W = 1 + EXP_W + MAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [3:0]        mode,
    input  logic              rec_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] res,
    output logic              flag_invalid,
    output logic              cond_valid,
    output logic [COND_W-1:0] cond
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] val;
        logic              inv;
        logic              crv;
        logic [COND_W-1:0] crf;
    } stage_t;

    logic [1:0][DATA_W-1:0] opnd;
    logic [1:0]             nan_v;
    logic [1:0]             snan_v;
    logic [1:0]             zero_v;

    logic key_lt, key_gt, num_lt, num_gt, num_eq, unord, mag_lt, mag_gt;
    logic [DATA_W-1:0] sel_val;

    stage_t st_d;
    stage_t st_q;

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) cls_i (
            .x       (opnd[g]),
            .is_nan  (nan_v[g]),
            .is_snan (snan_v[g]),
            .is_zero (zero_v[g])
        );
    end

    fmm_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) ord_i (
        .a      (op_a),
        .b      (op_b),
        .a_nan  (nan_v[0]),
        .b_nan  (nan_v[1]),
        .a_zero (zero_v[0]),
        .b_zero (zero_v[1]),
        .key_lt (key_lt),
        .key_gt (key_gt),
        .num_lt (num_lt),
        .num_gt (num_gt),
        .num_eq (num_eq),
        .unord  (unord),
        .mag_lt (mag_lt),
        .mag_gt (mag_gt)
    );

    fmm_select #(.EXP_W(EXP_W), .MAN_W(MAN_W)) sel_i (
        .mode   (mode),
        .a      (op_a),
        .b      (op_b),
        .a_nan  (nan_v[0]),
        .b_nan  (nan_v[1]),
        .a_snan (snan_v[0]),
        .b_snan (snan_v[1]),
        .key_lt (key_lt),
        .key_gt (key_gt),
        .num_lt (num_lt),
        .num_gt (num_gt),
        .mag_lt (mag_lt),
        .mag_gt (mag_gt),
        .res    (sel_val)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.val = sel_val;
            st_d.inv = |snan_v;
            st_d.crv = rec_en;
            st_d.crf = '0;
            if (rec_en) begin
                st_d.crf[COND_LT] = num_lt;
                st_d.crf[COND_GT] = num_gt;
                st_d.crf[COND_EQ] = num_eq;
                st_d.crf[COND_UN] = unord;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.vld;
    assign res          = st_q.val;
    assign flag_invalid = st_q.inv;
    assign cond_valid   = st_q.crv;
    assign cond         = st_q.crf;
endmodule

// File: rtl/fminmax_unit_chk.sv
module fminmax_unit_chk #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    localparam int DATA_W = 1 + EXP_W + MAN_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic [3:0]        mode,
    input logic              rec_en,
    input logic              out_valid,
    input logic [DATA_W-1:0] res,
    input logic              flag_invalid,
    input logic              cond_valid,
    input logic [3:0]        cond
);
    localparam logic [DATA_W-1:0] QBIT = DATA_W'(1) << (MAN_W - 1);

    logic a_nan_c, b_nan_c, a_sig_c, b_sig_c;
    assign a_nan_c = (&op_a[DATA_W-2 -: EXP_W]) && (|op_a[MAN_W-1:0]);
    assign b_nan_c = (&op_b[DATA_W-2 -: EXP_W]) && (|op_b[MAN_W-1:0]);
    assign a_sig_c = a_nan_c && !op_a[MAN_W-1];
    assign b_sig_c = b_nan_c && !op_b[MAN_W-1];

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (a_sig_c || b_sig_c) |=> flag_invalid);
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !a_sig_c && !b_sig_c |=> !flag_invalid);
    assert_cond_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cond_valid |-> $countones(cond) == 1);
    assert_cond_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !rec_en |=> (cond == 4'd0) && !cond_valid);
    assert_plain_nan_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (mode[1:0] == 2'b11) && a_nan_c |=> res == $past(op_b));
    assert_prop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (mode[1:0] == 2'b01) && a_nan_c |=> res == ($past(op_a) | QBIT));
    assert_num19_other_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (mode[1:0] == 2'b10) && a_nan_c && !b_nan_c |=> res == $past(op_b));
endmodule

bind fminmax_unit fminmax_unit_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .op_a         (op_a),
    .op_b         (op_b),
    .mode         (mode),
    .rec_en       (rec_en),
    .out_valid    (out_valid),
    .res          (res),
    .flag_invalid (flag_invalid),
    .cond_valid   (cond_valid),
    .cond         (cond)
);

// File: tb/fminmax_unit_tb_top.sv
module fminmax_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] QB = 64'h0008_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [3:0]  mode = '0;
    logic        rec_en = 1'b0;
    logic        out_valid, flag_invalid, cond_valid;
    logic [63:0] res;
    logic [3:0]  cond;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fminmax_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .mode(mode), .rec_en(rec_en), .out_valid(out_valid), .res(res),
        .flag_invalid(flag_invalid), .cond_valid(cond_valid), .cond(cond)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic bit f_nan(logic [63:0] x);
        return (x[62:52] == 11'h7ff) && (x[51:0] != 0);
    endfunction
    function automatic bit f_snan(logic [63:0] x);
        return f_nan(x) && !x[51];
    endfunction
    // numeric less-than with -0 below +0, non-NaN operands only
    function automatic bit lt_sz(logic [63:0] x, logic [63:0] y);
        real rx = $bitstoreal(x);
        real ry = $bitstoreal(y);
        if (rx < ry) return 1;
        if (rx > ry) return 0;
        return x[63] && !y[63];
    endfunction
    function automatic logic [63:0] ord_pick(logic [63:0] x, logic [63:0] y, bit mx);
        if (mx) return lt_sz(x, y) ? y : x;
        return lt_sz(y, x) ? y : x;
    endfunction
    function automatic logic [63:0] base_ref(logic [63:0] x, logic [63:0] y, logic [1:0] r, bit mx);
        bit xn = f_nan(x);
        bit yn = f_nan(y);
        case (r)
            2'b00: begin
                if (f_snan(x)) return x | QB;
                if (f_snan(y)) return y | QB;
                if (xn && yn) return x | QB;
                if (xn) return y;
                if (yn) return x;
                return ord_pick(x, y, mx);
            end
            2'b01: begin
                if (xn) return x | QB;
                if (yn) return y | QB;
                return ord_pick(x, y, mx);
            end
            2'b10: begin
                if (xn && yn) return x | QB;
                if (xn) return y;
                if (yn) return x;
                return ord_pick(x, y, mx);
            end
            default: begin
                if (xn || yn) return y;
                if (mx) return ($bitstoreal(x) > $bitstoreal(y)) ? x : y;
                return ($bitstoreal(x) < $bitstoreal(y)) ? x : y;
            end
        endcase
    endfunction
    function automatic logic [63:0] ref_res(logic [63:0] x, logic [63:0] y, logic [3:0] m);
        real ax, ay;
        if (m[2] && !f_nan(x) && !f_nan(y)) begin
            ax = $bitstoreal({1'b0, x[62:0]});
            ay = $bitstoreal({1'b0, y[62:0]});
            if (ax < ay) return m[3] ? y : x;
            if (ax > ay) return m[3] ? x : y;
        end
        return base_ref(x, y, m[1:0], m[3]);
    endfunction
    function automatic logic [3:0] ref_cond(logic [63:0] x, logic [63:0] y, bit rc);
        real rx = $bitstoreal(x);
        real ry = $bitstoreal(y);
        if (!rc) return 4'b0000;
        if (f_nan(x) || f_nan(y)) return 4'b0001;
        return {rx < ry, rx > ry, rx == ry, 1'b0};
    endfunction
    function automatic string res_tag(logic [3:0] m);
        if (m[2]) return "R7";
        case (m[1:0])
            2'b00: return "R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    // caller stands at a negedge; drive, let one posedge pass, check
    task automatic do_op(logic [63:0] x, logic [63:0] y, logic [3:0] m, bit rc);
        op_a = x; op_b = y; mode = m; rec_en = rc; in_valid = 1'b1;
        @(negedge clk);
        chk("R2 out_valid", 64'(out_valid), 64'd1);
        chk(res_tag(m), res, ref_res(x, y, m));
        chk("R10 flag", 64'(flag_invalid), 64'(f_snan(x) || f_snan(y)));
        chk("R11 cond", 64'({cond_valid, cond}), 64'({rc, ref_cond(x, y, rc)}));
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction
    function automatic logic [63:0] pick_val();
        logic [63:0] r = rnd64();
        logic [10:0] e;
        case ($urandom % 10)
            0: return 64'h0000_0000_0000_0000;
            1: return 64'h8000_0000_0000_0000;
            2: return 64'h7FF0_0000_0000_0000;
            3: return 64'hFFF0_0000_0000_0000;
            4: return {r[63], 11'h7ff, 1'b1, r[50:0]};
            5: return {r[63], 11'h7ff, 1'b0, r[50:1], 1'b1};
            6: return {r[63], 11'h000, r[51:0]};
            default: begin
                e = r[62:52];
                if (e == 11'h000 || e == 11'h7ff) e = 11'h3ff;
                return {r[63], e, r[51:0]};
            end
        endcase
    endfunction

    localparam int NDIR = 14;
    logic [63:0] dir_a [NDIR];
    logic [63:0] dir_b [NDIR];

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        dir_a[0]  = 64'h0000_0000_0000_0000; dir_b[0]  = 64'h8000_0000_0000_0000;
        dir_a[1]  = 64'h8000_0000_0000_0000; dir_b[1]  = 64'h0000_0000_0000_0000;
        dir_a[2]  = 64'h3FF0_0000_0000_0000; dir_b[2]  = 64'h7FF8_0000_0000_0000;
        dir_a[3]  = 64'h7FF8_0000_0000_0001; dir_b[3]  = 64'h3FF0_0000_0000_0000;
        dir_a[4]  = 64'h7FF0_0000_0000_0005; dir_b[4]  = 64'h4000_0000_0000_0000;
        dir_a[5]  = 64'h4000_0000_0000_0000; dir_b[5]  = 64'hFFF0_0000_0000_0003;
        dir_a[6]  = 64'h7FF8_0000_0000_0000; dir_b[6]  = 64'h7FF0_0000_0000_0007;
        dir_a[7]  = 64'hFFF8_0000_0000_0002; dir_b[7]  = 64'h7FF8_0000_0000_0009;
        dir_a[8]  = 64'hC008_0000_0000_0000; dir_b[8]  = 64'h4008_0000_0000_0000;
        dir_a[9]  = 64'h7FF0_0000_0000_0000; dir_b[9]  = 64'hFFF0_0000_0000_0000;
        dir_a[10] = 64'h0000_0000_0000_0010; dir_b[10] = 64'h8000_0000_0000_0020;
        dir_a[11] = 64'h3FF8_0000_0000_0000; dir_b[11] = 64'h4004_0000_0000_0000;
        dir_a[12] = 64'hBFF8_0000_0000_0000; dir_b[12] = 64'h3FE0_0000_0000_0000;
        dir_a[13] = 64'h4010_0000_0000_0000; dir_b[13] = 64'h4010_0000_0000_0000;

        repeat (3) @(negedge clk);
        chk("R1 reset", {out_valid, flag_invalid, cond_valid, cond, res[56:0]}, 64'd0);
        chk("R1 reset res", res, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle after reset", 64'(out_valid), 64'd0);

        for (int m = 0; m < 16; m++)
            for (int i = 0; i < NDIR; i++)
                do_op(dir_a[i], dir_b[i], 4'(m), bit'((i + m) % 2));

        // R8: same operands, min versus max of the plain rule
        do_op(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 4'b0011, 1'b1);
        chk("R8 min picks A", res, 64'h3FF0_0000_0000_0000);
        do_op(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 4'b1011, 1'b1);
        chk("R8 max picks B", res, 64'h4000_0000_0000_0000);
        // R9: signalling NaN returned quieted with payload kept
        do_op(64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000, 4'b0001, 1'b0);
        chk("R9 quieted", res, 64'h7FF8_0000_0000_0001);
        // R7: magnitude tie falls back to signed-zero order of rule 01
        do_op(64'h4008_0000_0000_0000, 64'hC008_0000_0000_0000, 4'b0101, 1'b1);
        chk("R7 tie fallback", res, 64'hC008_0000_0000_0000);
        chk("R11 unequal", 64'(cond), 64'b0100);

        // R2: idle cycle holds out_valid low
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2 idle", 64'(out_valid), 64'd0);

        for (int k = 0; k < 4000; k++) begin
            logic [63:0] x = pick_val();
            logic [63:0] y = pick_val();
            int s = int'($urandom % 8);
            if (s == 0) y = {~x[63], x[62:0]};
            else if (s == 1) y = x;
            do_op(x, y, 4'($urandom), bit'($urandom));
        end

        in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule